// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block chooses which of a small set of physical page frames should give up its page when a new page must be brought in. It keeps a use flag and a pin flag for every frame, together with a circular hand. Each use flag records recent activity: loading a page into a frame raises it, and so does every reference to that frame's page. When a victim is requested, the hand sweeps forward one frame per clock cycle. It lowers the use flag of each unpinned frame it passes, and it stops at the first unpinned frame whose flag is already low. Pinned frames are stepped over untouched and are never chosen.

Surrounding logic issues a request through a valid/ready pair. The request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low for the whole sweep, so further requests are held off and are not lost. The result is a single-cycle `done` pulse carrying either a victim index or, when every frame was pinned for a full lap, the `all_locked` flag. The result side has no back-pressure: the consumer must capture the result on the pulse. Page table updates and transfers to backing store belong to other blocks.

Top module: `clock_victim_picker`

## Requirements
- R1: After reset the hand points at frame 0, every use flag and pin flag is clear, `req_ready` is 1 and `done` is 0.
- R2: A `load_valid` strobe sets the use flag of frame `load_frame` on the next clock edge.
- R3: A `ref_valid` strobe sets the use flag of frame `ref_frame` on the next clock edge.
- R4: A sweep examines one frame per cycle, starting at the hand. The first unpinned frame whose use flag is 0 becomes the victim. `done` pulses high for one cycle on the edge that examines that frame, with `victim` holding its index and `all_locked` at 0. A request accepted at edge E0 whose victim is the k-th frame examined produces `done` after edge E0+k.
- R5: Every unpinned frame that the sweep passes with its use flag at 1 has that flag cleared.
- R6: After a victim is chosen, the hand points to the frame after the victim, wrapping from frame 7 to frame 0.
- R7: A frame pinned with `lock_valid`/`lock_frame` is stepped over without being chosen or having its use flag changed, until `unlock_valid`/`unlock_frame` releases it. If both strobes name the same frame, the pin wins.
- R8: If every frame has its use flag at 1 and none is pinned, the sweep clears all eight flags, returns to the frame where it began and chooses that frame, 9 cycles after acceptance.
- R9: If eight consecutive examinations all meet pinned frames, the sweep ends with `done` and `all_locked` both high, 8 cycles after acceptance, and the hand is left where the sweep began.
- R10: If a reference or load strobe names the frame that the sweep is clearing in that same cycle, the strobe wins and the flag stays 1.
- R11: `req_ready` is low from the edge that accepts a request until the sweep's `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Page in a frame was referenced |
| ref_frame | input | 3 | Frame index for the reference |
| load_valid | input | 1 | A page was loaded into a frame |
| load_frame | input | 3 | Frame index for the load |
| lock_valid | input | 1 | Pin a frame against replacement |
| lock_frame | input | 3 | Frame index to pin |
| unlock_valid | input | 1 | Release a pinned frame |
| unlock_frame | input | 3 | Frame index to release |
| req_valid | input | 1 | Victim request, valid side |
| req_ready | output | 1 | High when no sweep is in progress |
| done | output | 1 | One-cycle result pulse |
| victim | output | 3 | Chosen frame index, meaningful with `done` and not `all_locked` |
| all_locked | output | 1 | With `done`: a full lap met only pinned frames |

## Verification
The sweep clearing a frame's use flag and a reference strobe setting that same flag can land in the same cycle. The bench provokes this by pinning all frames but one and loading that one. It starts a sweep from a known hand and raises `ref_valid` for that frame exactly in the cycle the hand reaches it. If the reference wins, the frame survives one more lap and the result arrives after 20 cycles. If the clear wins, it arrives after 12. The victim index and the cycle count are both judged against the bench's model.

// File: rtl/clk_repl_pkg.sv
package clk_repl_pkg;
  typedef enum logic [0:0] {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/clk_idx_decode.sv
module clk_idx_decode #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [N_FRAMES-1:0] mask
);
  for (genvar i = 0; i < N_FRAMES; i++) begin : g_dec
    assign mask[i] = en && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/clk_flag_bank.sv
// Per-frame flag register; set has priority over clear in the same cycle.
module clk_flag_bank #(
  parameter int N_FRAMES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_FRAMES-1:0] set_mask,
  input  logic [N_FRAMES-1:0] clr_mask,
  output logic [N_FRAMES-1:0] flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/clk_hand_scanner.sv
module clk_hand_scanner
  import clk_repl_pkg::*;
#(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_FRAMES-1:0] use_bits,
  input  logic [N_FRAMES-1:0] lock_bits,
  input  logic                req_valid,
  output logic                req_ready,
  output logic [N_FRAMES-1:0] clr_mask,
  output logic                done,
  output logic [IDX_W-1:0]    victim,
  output logic                all_locked,
  output logic [IDX_W-1:0]    hand
);
  localparam logic [IDX_W-1:0] HAND_LAST = IDX_W'(N_FRAMES - 1);
  localparam logic [IDX_W:0]   SKIP_LAST = (IDX_W + 1)'(N_FRAMES - 1);

  sweep_state_e     state_q;
  logic [IDX_W-1:0] hand_q;
  logic [IDX_W:0]   skip_q;
  logic             done_q, err_q;
  logic [IDX_W-1:0] victim_q;

  logic             cur_locked, cur_used, passing;
  logic [IDX_W-1:0] hand_nx;

  assign cur_locked = lock_bits[hand_q];
  assign cur_used   = use_bits[hand_q];
  assign hand_nx    = (hand_q == HAND_LAST) ? '0 : hand_q + 1'b1;
  assign passing    = (state_q == SWEEP_RUN) && !cur_locked && cur_used;

  for (genvar i = 0; i < N_FRAMES; i++) begin : g_clr
    assign clr_mask[i] = passing && (hand_q == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SWEEP_IDLE;
      hand_q   <= '0;
      skip_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      victim_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SWEEP_IDLE: begin
          if (req_valid) begin
            state_q <= SWEEP_RUN;
            skip_q  <= '0;
          end
        end
        SWEEP_RUN: begin
          hand_q <= hand_nx;
          if (cur_locked) begin
            if (skip_q == SKIP_LAST) begin
              done_q   <= 1'b1;
              err_q    <= 1'b1;
              victim_q <= '0;
              state_q  <= SWEEP_IDLE;
            end else begin
              skip_q <= skip_q + 1'b1;
            end
          end else if (!cur_used) begin
            done_q   <= 1'b1;
            err_q    <= 1'b0;
            victim_q <= hand_q;
            state_q  <= SWEEP_IDLE;
          end else begin
            skip_q <= '0;
          end
        end
        default: state_q <= SWEEP_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == SWEEP_IDLE);
  assign done       = done_q;
  assign victim     = victim_q;
  assign all_locked = done_q && err_q;
  assign hand       = hand_q;
endmodule

// File: rtl/clock_victim_picker.sv
module clock_victim_picker #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_frame,
  input  logic             load_valid,
  input  logic [IDX_W-1:0] load_frame,
  input  logic             lock_valid,
  input  logic [IDX_W-1:0] lock_frame,
  input  logic             unlock_valid,
  input  logic [IDX_W-1:0] unlock_frame,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             done,
  output logic [IDX_W-1:0] victim,
  output logic             all_locked
);
  logic [N_FRAMES-1:0] ref_mask, load_mask, lock_mask, unlock_mask;
  logic [N_FRAMES-1:0] use_q, lock_q, sweep_clr;
  logic [IDX_W-1:0]    hand_q;

  clk_idx_decode #(.N_FRAMES(N_FRAMES)) dec_ref_i (
    .en(ref_valid), .idx(ref_frame), .mask(ref_mask));
  clk_idx_decode #(.N_FRAMES(N_FRAMES)) dec_load_i (
    .en(load_valid), .idx(load_frame), .mask(load_mask));
  clk_idx_decode #(.N_FRAMES(N_FRAMES)) dec_lock_i (
    .en(lock_valid), .idx(lock_frame), .mask(lock_mask));
  clk_idx_decode #(.N_FRAMES(N_FRAMES)) dec_unlock_i (
    .en(unlock_valid), .idx(unlock_frame), .mask(unlock_mask));

  // Activity beats the sweep's clear on a collision.
  clk_flag_bank #(.N_FRAMES(N_FRAMES)) use_bank_i (
    .clk(clk), .rst_n(rst_n),
    .set_mask(ref_mask | load_mask), .clr_mask(sweep_clr), .flags(use_q));

  // Pinning beats releasing on a collision.
  clk_flag_bank #(.N_FRAMES(N_FRAMES)) lock_bank_i (
    .clk(clk), .rst_n(rst_n),
    .set_mask(lock_mask), .clr_mask(unlock_mask), .flags(lock_q));

  clk_hand_scanner #(.N_FRAMES(N_FRAMES)) scan_i (
    .clk(clk), .rst_n(rst_n),
    .use_bits(use_q), .lock_bits(lock_q),
    .req_valid(req_valid), .req_ready(req_ready),
    .clr_mask(sweep_clr),
    .done(done), .victim(victim), .all_locked(all_locked),
    .hand(hand_q));
endmodule

// File: rtl/clk_repl_checker.sv
module clk_repl_checker #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ref_valid,
  input logic [IDX_W-1:0]    ref_frame,
  input logic                load_valid,
  input logic [IDX_W-1:0]    load_frame,
  input logic                req_valid,
  input logic                req_ready,
  input logic                done,
  input logic [IDX_W-1:0]    victim,
  input logic                all_locked,
  input logic [N_FRAMES-1:0] use_q,
  input logic [N_FRAMES-1:0] lock_q,
  input logic [IDX_W-1:0]    hand_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FRAMES - 1);
  logic [N_FRAMES-1:0] use_prev, lock_prev;

  always_ff @(posedge clk) begin
    use_prev  <= use_q;
    lock_prev <= lock_q;
  end

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_victim_was_unused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !all_locked && !$rose(rst_n)) |-> !use_prev[victim]);
  assert_victim_unpinned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !all_locked && !$rose(rst_n)) |-> !lock_prev[victim]);
  assert_hand_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !all_locked) |-> hand_q == ((victim == LAST) ? '0 : victim + 1'b1));
  assert_load_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> use_q[$past(load_frame)]);
  assert_ref_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> use_q[$past(ref_frame)]);
endmodule

bind clock_victim_picker clk_repl_checker #(.N_FRAMES(N_FRAMES)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .ref_valid(ref_valid), .ref_frame(ref_frame),
  .load_valid(load_valid), .load_frame(load_frame),
  .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .victim(victim), .all_locked(all_locked),
  .use_q(use_q), .lock_q(lock_q), .hand_q(hand_q));

// File: tb/clock_victim_picker_tb_top.sv
`timescale 1ns/1ps
module clock_victim_picker_tb_top;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic ref_valid = 0, load_valid = 0, lock_valid = 0, unlock_valid = 0, req_valid = 0;
  logic [2:0] ref_frame = 0, load_frame = 0, lock_frame = 0, unlock_frame = 0;
  logic req_ready, done, all_locked;
  logic [2:0] victim;

  int total = 0, bad = 0;
  bit finished = 0;
  bit m_use[N], m_lock[N];
  int m_hand = 0;

  always #4 clk = ~clk;

  clock_victim_picker dut_i (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic pulse(input int kind, input int f);
    @(negedge clk);
    case (kind)
      0: begin ref_valid = 1; ref_frame = 3'(f); end
      1: begin load_valid = 1; load_frame = 3'(f); end
      2: begin lock_valid = 1; lock_frame = 3'(f); end
      default: begin unlock_valid = 1; unlock_frame = 3'(f); end
    endcase
    @(negedge clk);
    ref_valid = 0; load_valid = 0; lock_valid = 0; unlock_valid = 0;
    case (kind)
      0, 1: m_use[f] = 1;
      2: m_lock[f] = 1;
      default: m_lock[f] = 0;
    endcase
  endtask

  // Model of the sweep, from the requirements.
  task automatic model_sweep(output int v, output bit e, output int lat);
    int skip = 0;
    v = 0; e = 0; lat = 0;
    for (int s = 0; s < 100; s++) begin
      int h = m_hand;
      lat++;
      m_hand = (m_hand + 1) % N;
      if (m_lock[h]) begin
        if (skip == N - 1) begin e = 1; return; end
        skip++;
      end else if (!m_use[h]) begin
        v = h; return;
      end else begin
        m_use[h] = 0; skip = 0;
      end
    end
  endtask

  // Issue a request; optionally raise a reference to coll_f after coll_at edges.
  task automatic run_req(input string tag, input int exp_v, input bit exp_e,
                         input int exp_lat, input int coll_at, input int coll_f);
    int n = 0;
    bit got = 0;
    @(negedge clk);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (n < 40) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n == coll_at) begin ref_valid = 1; ref_frame = 3'(coll_f); end
      if (n == coll_at + 1) ref_valid = 0;
      if (done) begin got = 1; break; end
      if (n == 1) check(req_ready == 0, {tag, " R11 ready low while busy"}, int'(req_ready), 0);
    end
    ref_valid = 0;
    check(got, {tag, " R4 done seen"}, int'(got), 1);
    check(n == exp_lat, {tag, " R4 latency"}, n, exp_lat);
    check(all_locked == exp_e, {tag, " R9 all_locked"}, int'(all_locked), int'(exp_e));
    if (!exp_e) check(int'(victim) == exp_v, {tag, " R4 victim"}, int'(victim), exp_v);
  endtask

  task automatic model_req(input string tag);
    int v, lat; bit e;
    model_sweep(v, e, lat);
    run_req(tag, v, e, lat, -5, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
    check(done == 0, "R1 done low after reset", int'(done), 0);

    model_req("R1 first victim frame 0");
    model_req("R6 hand moved past victim");
    pulse(1, 2); pulse(0, 3);
    model_req("R2 R3 R5 used frames passed");
    model_req("R5 cleared frames now chosen");

    for (int f = 0; f < N; f++) pulse(1, f);
    model_req("R8 full lap returns to start");

    for (int f = 0; f < N; f++) if (f != 6) pulse(2, f);
    model_req("R7 only unpinned frame");
    pulse(2, 6);
    model_req("R9 all pinned");
    for (int f = 0; f < N; f++) pulse(3, f);
    model_req("R7 released frames eligible");

    // R10 collision: only frame k unpinned and used, reference lands as hand reaches it.
    begin
      int k = (m_hand + 3) % N;
      for (int f = 0; f < N; f++) if (f != k) pulse(2, f);
      pulse(1, k);
      run_req("R10 reference beats clear", k, 0, 20, 3, k);
      m_use[k] = 0;
      m_hand = (k + 1) % N;
      for (int f = 0; f < N; f++) pulse(3, f);
    end

    for (int it = 0; it < 150; it++) begin
      int ops = $urandom_range(3, 0);
      for (int o = 0; o < ops; o++) begin
        int kind = $urandom_range(9, 0);
        int f = $urandom_range(N - 1, 0);
        if (kind < 4) pulse(0, f);
        else if (kind < 6) pulse(1, f);
        else if (kind < 7) pulse(2, f);
        else pulse(3, f);
      end
      begin
        int v, lat; bit e;
        model_sweep(v, e, lat);
        run_req("R4 R5 R7 random", v, e, lat, -5, 0);
        if (!e) pulse(1, v);
      end
    end
    summary();
  end
endmodule